// File: doc/BRIEF.md
# Auto-Precharge Inter-Bank Command Timer

This block sits in the command path of a multi-bank DDR-style memory controller. It decides, cycle by cycle, whether each kind of command may go to the bank named on `cmd_bank`. It keeps two kinds of state. The first is a set of down-counters for each class of follow-on command, loaded whenever a READ or WRITE is accepted with auto precharge. The second is the open/closed state and the precharge-period counter of every bank. From these it drives one ready line per command type. Any command presented while its ready line is low is refused and raises a sticky violation flag.

The command strobe is a valid/ready pair without back-pressure storage. The scheduler looks at the ready line that matches `cmd_code` and `cmd_bank` in the same cycle, and raises `cmd_valid` only when that line is high. A command that is presented while its ready line is low is not stalled or queued. It is dropped, it leaves all timing and bank state untouched, and it sets `viol`, which only reset clears. The configuration inputs are whole-clock values, except CAS latency, which is given in half clocks. They are expected to stay constant while traffic flows.

Top module: `ap_bank_timer`

## Requirements
- R1: Command codes on `cmd_code` are 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 6 MODE LOAD. ACTIVE needs the target bank closed and out of any precharge period. READ and WRITE need the target bank open. PRECHARGE needs the target bank out of any precharge period.
- R2: After an accepted WRITE with `cmd_ap`=1, a READ to another bank waits WL + BL/2 + WTR clocks and a WRITE to another bank waits BL/2 clocks.
- R3: After an accepted READ with `cmd_ap`=1, a READ to another bank waits BL/2 clocks and a WRITE waits CL + BL/2 + 2 − WL clocks, or no clocks when that value is not positive.
- R4: After an auto-precharge access, an ACTIVE or PRECHARGE to another bank is allowed from the next clock.
- R5: CL is `cfg_cl_half` (half clocks) rounded up to whole clocks before it enters any spacing.
- R6: A bank stays busy after its command for WL + BL/2 + WR + RP clocks after a WRITE with auto precharge, BL/2 + RP after a READ with auto precharge, and RP after an explicit PRECHARGE.
- R7: REFRESH and MODE LOAD are ready only when every bank is closed and out of its precharge period.
- R8: A command presented while its ready line is low sets `viol`, which stays set until reset, and the refused command changes no bank or timing state.
- R9: NOP is always accepted with no effect. The reserved code 7 is never accepted and sets `viol`.
- R10: Reset closes every bank, clears every counter and clears `viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command presented this cycle |
| cmd_code | input | 3 | Command type code (R1) |
| cmd_ap | input | 1 | Auto precharge flag for READ/WRITE |
| cmd_bank | input | BAW | Target bank |
| cfg_cl_half | input | CFGW | CAS latency in half clocks |
| cfg_wl | input | CFGW | Write latency, clocks |
| cfg_bl | input | CFGW | Burst length, beats |
| cfg_wtr | input | CFGW | Write-to-read turnaround, clocks |
| cfg_wr | input | CFGW | Write recovery, clocks |
| cfg_rp | input | CFGW | Precharge period, clocks |
| rdy_act | output | 1 | ACTIVE to `cmd_bank` may issue |
| rdy_rd | output | 1 | READ to `cmd_bank` may issue |
| rdy_wr | output | 1 | WRITE to `cmd_bank` may issue |
| rdy_pre | output | 1 | PRECHARGE to `cmd_bank` may issue |
| rdy_ref | output | 1 | REFRESH may issue |
| rdy_mrs | output | 1 | MODE LOAD may issue |
| viol | output | 1 | Sticky: a command was presented while not ready |

## Verification
The stimulus opens all banks and then puts a write with auto precharge, a read with auto precharge and an explicit precharge in turn in front of a stream of probe cycles. In those probe cycles the bench watches the ready line of another bank's READ, WRITE or ACTIVE without issuing it. This separates the four cross-type spacings, and it separates the one-clock ACTIVE/PRECHARGE rule from the longer bank busy periods. A refresh probe held across overlapping busy windows checks that refresh waits for the last bank to go idle. Two further configurations come after a reset. One uses an even half-clock CAS latency, so that an off-by-one in the rounding shows up. The other drives the read-to-write spacing below zero, so that an unclamped subtraction shows up. Refused commands, a NOP and the reserved code close the run, and they show whether a refused command leaks into bank state.

// File: rtl/ap_timer_pkg.sv
package ap_timer_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_RSV = 3'd7
  } cmd_e;

  // Follow-on command classes timed after an auto-precharge access
  localparam int CLS_RD = 0;
  localparam int CLS_WR = 1;
  localparam int CLS_PA = 2;
  localparam int NUM_CLS = 3;
endpackage

// File: rtl/ap_gap_calc.sv
// Turns configuration into clock spacings and bank busy spans.
module ap_gap_calc #(
  parameter int CFGW = 6,
  parameter int CNTW = 9
) (
  input  logic [CFGW-1:0] cl_half,
  input  logic [CFGW-1:0] wl,
  input  logic [CFGW-1:0] bl,
  input  logic [CFGW-1:0] wtr,
  input  logic [CFGW-1:0] wr_rec,
  input  logic [CFGW-1:0] rp,
  output logic [CNTW-1:0] wra_rd_gap,
  output logic [CNTW-1:0] wra_wr_gap,
  output logic [CNTW-1:0] rda_rd_gap,
  output logic [CNTW-1:0] rda_wr_gap,
  output logic [CNTW-1:0] wra_span,
  output logic [CNTW-1:0] rda_span,
  output logic [CNTW-1:0] pre_span
);
  logic [CNTW-1:0] cl_clk, half_bl, wl_w, wtr_w, wr_w, rp_w, rda_lead;

  always_comb begin
    cl_clk   = (CNTW'(cl_half) + CNTW'(1)) >> 1;   // round half clocks up
    half_bl  = CNTW'(bl) >> 1;
    wl_w     = CNTW'(wl);
    wtr_w    = CNTW'(wtr);
    wr_w     = CNTW'(wr_rec);
    rp_w     = CNTW'(rp);
    rda_lead = cl_clk + half_bl + CNTW'(2);

    wra_rd_gap = wl_w + half_bl + wtr_w;
    wra_wr_gap = half_bl;
    rda_rd_gap = half_bl;
    rda_wr_gap = (rda_lead > wl_w) ? (rda_lead - wl_w) : '0;

    wra_span = wl_w + half_bl + wr_w + rp_w;
    rda_span = half_bl + rp_w;
    pre_span = rp_w;
  end
endmodule

// File: rtl/ap_class_timer.sv
// Down-counter holding off one class of follow-on command.
module ap_class_timer #(
  parameter int CNTW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CNTW-1:0] gap,
  output logic            clear
);
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (gap == '0) ? '0 : gap - CNTW'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNTW'(1);
    end
  end

  assign clear = (cnt == '0);
endmodule

// File: rtl/ap_bank_tracker.sv
// Per-bank open flag and precharge-period counter.
module ap_bank_tracker
  import ap_timer_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BAW       = 2,
  parameter int CNTW      = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  cmd_e                 code,
  input  logic                 ap,
  input  logic [BAW-1:0]       bank,
  input  logic [CNTW-1:0]      wra_span,
  input  logic [CNTW-1:0]      rda_span,
  input  logic [CNTW-1:0]      pre_span,
  output logic [NUM_BANKS-1:0] open_o,
  output logic [NUM_BANKS-1:0] quiet_o,
  output logic [NUM_BANKS-1:0] idle_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNTW-1:0] busy;
    logic [CNTW-1:0] span;
    logic            is_open;
    logic            hit;
    logic            start;

    assign hit = take && (bank == BAW'(b));

    always_comb begin
      start = 1'b0;
      span  = '0;
      if (hit) begin
        case (code)
          CMD_PRE: begin start = 1'b1; span = pre_span; end
          CMD_RD:  if (ap) begin start = 1'b1; span = rda_span; end
          CMD_WR:  if (ap) begin start = 1'b1; span = wra_span; end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        is_open <= 1'b0;
        busy    <= '0;
      end else begin
        if (hit && code == CMD_ACT) is_open <= 1'b1;
        else if (start)             is_open <= 1'b0;
        if (start)                  busy <= (span == '0) ? '0 : span - CNTW'(1);
        else if (busy != '0)        busy <= busy - CNTW'(1);
      end
    end

    assign open_o[b]  = is_open;
    assign quiet_o[b] = (busy == '0);
    assign idle_o[b]  = !is_open && (busy == '0);
  end
endmodule

// File: rtl/ap_bank_timer.sv
module ap_bank_timer
  import ap_timer_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CFGW      = 6,
  parameter int CNTW      = 9,
  localparam int BAW      = $clog2(NUM_BANKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_code,
  input  logic            cmd_ap,
  input  logic [BAW-1:0]  cmd_bank,
  input  logic [CFGW-1:0] cfg_cl_half,
  input  logic [CFGW-1:0] cfg_wl,
  input  logic [CFGW-1:0] cfg_bl,
  input  logic [CFGW-1:0] cfg_wtr,
  input  logic [CFGW-1:0] cfg_wr,
  input  logic [CFGW-1:0] cfg_rp,
  output logic            rdy_act,
  output logic            rdy_rd,
  output logic            rdy_wr,
  output logic            rdy_pre,
  output logic            rdy_ref,
  output logic            rdy_mrs,
  output logic            viol
);
  cmd_e                 code;
  logic                 cmd_ok;
  logic                 cmd_take;
  logic                 ap_load;
  logic [NUM_BANKS-1:0] open_v, quiet_v, idle_v;
  logic [NUM_CLS-1:0]   cls_clear;
  logic [CNTW-1:0]      cls_gap [NUM_CLS];
  logic [CNTW-1:0]      wra_rd_gap, wra_wr_gap, rda_rd_gap, rda_wr_gap;
  logic [CNTW-1:0]      wra_span, rda_span, pre_span;

  assign code = cmd_e'(cmd_code);

  ap_gap_calc #(.CFGW(CFGW), .CNTW(CNTW)) u_gap (
    .cl_half(cfg_cl_half), .wl(cfg_wl), .bl(cfg_bl), .wtr(cfg_wtr),
    .wr_rec(cfg_wr), .rp(cfg_rp),
    .wra_rd_gap(wra_rd_gap), .wra_wr_gap(wra_wr_gap),
    .rda_rd_gap(rda_rd_gap), .rda_wr_gap(rda_wr_gap),
    .wra_span(wra_span), .rda_span(rda_span), .pre_span(pre_span)
  );

  ap_bank_tracker #(.NUM_BANKS(NUM_BANKS), .BAW(BAW), .CNTW(CNTW)) u_banks (
    .clk(clk), .rst_n(rst_n), .take(cmd_take), .code(code), .ap(cmd_ap),
    .bank(cmd_bank), .wra_span(wra_span), .rda_span(rda_span),
    .pre_span(pre_span), .open_o(open_v), .quiet_o(quiet_v), .idle_o(idle_v)
  );

  // Spacing chosen by the earlier access type for each later class
  always_comb begin
    cls_gap[CLS_RD] = (code == CMD_WR) ? wra_rd_gap : rda_rd_gap;
    cls_gap[CLS_WR] = (code == CMD_WR) ? wra_wr_gap : rda_wr_gap;
    cls_gap[CLS_PA] = CNTW'(1);
  end

  assign ap_load = cmd_take && cmd_ap && (code == CMD_RD || code == CMD_WR);

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    ap_class_timer #(.CNTW(CNTW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(ap_load),
      .gap(cls_gap[c]), .clear(cls_clear[c])
    );
  end

  always_comb begin
    rdy_act = idle_v[cmd_bank]  && cls_clear[CLS_PA];
    rdy_pre = quiet_v[cmd_bank] && cls_clear[CLS_PA];
    rdy_rd  = open_v[cmd_bank]  && cls_clear[CLS_RD];
    rdy_wr  = open_v[cmd_bank]  && cls_clear[CLS_WR];
    rdy_ref = &idle_v;
    rdy_mrs = &idle_v;
    case (code)
      CMD_NOP: cmd_ok = 1'b1;
      CMD_ACT: cmd_ok = rdy_act;
      CMD_RD:  cmd_ok = rdy_rd;
      CMD_WR:  cmd_ok = rdy_wr;
      CMD_PRE: cmd_ok = rdy_pre;
      CMD_REF: cmd_ok = rdy_ref;
      CMD_MRS: cmd_ok = rdy_mrs;
      default: cmd_ok = 1'b0;
    endcase
  end

  assign cmd_take = cmd_valid && cmd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    viol <= 1'b0;
    else if (cmd_valid && !cmd_ok) viol <= 1'b1;
  end
endmodule

// File: rtl/ap_timer_chk.sv
module ap_timer_chk
  import ap_timer_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CFGW      = 6,
  localparam int BAW      = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_code,
  input logic                 cmd_ap,
  input logic [BAW-1:0]       cmd_bank,
  input logic [CFGW-1:0]      cfg_bl,
  input logic [CFGW-1:0]      cfg_rp,
  input logic                 rdy_act,
  input logic                 rdy_rd,
  input logic                 rdy_wr,
  input logic                 rdy_ref,
  input logic                 rdy_mrs,
  input logic                 viol,
  input logic [NUM_BANKS-1:0] bank_idle
);
  logic wra_take, rda_take, act_take;
  assign wra_take = cmd_valid && cmd_ap && cmd_code == CMD_WR && rdy_wr;
  assign rda_take = cmd_valid && cmd_ap && cmd_code == CMD_RD && rdy_rd;
  assign act_take = cmd_valid && cmd_code == CMD_ACT && rdy_act;

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol); // R8
  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol) |-> $past(cmd_valid)); // R8
  AST_WRA_HOLDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (wra_take && cfg_bl >= CFGW'(4)) |=> !rdy_rd); // R2
  AST_RDA_HOLDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (rda_take && cfg_bl >= CFGW'(4)) |=> !rdy_rd); // R3
  AST_AP_NEXT_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (wra_take || rda_take) |=> (rdy_act == bank_idle[cmd_bank])); // R4
  AST_AP_BLOCKS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ((wra_take || rda_take) && cfg_rp != '0) |=> (!rdy_ref && !rdy_mrs)); // R7
  AST_ACT_BLOCKS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    act_take |=> !rdy_ref); // R1
endmodule

bind ap_bank_timer ap_timer_chk #(.NUM_BANKS(NUM_BANKS), .CFGW(CFGW)) u_ap_timer_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_ap(cmd_ap), .cmd_bank(cmd_bank), .cfg_bl(cfg_bl), .cfg_rp(cfg_rp),
  .rdy_act(rdy_act), .rdy_rd(rdy_rd), .rdy_wr(rdy_wr), .rdy_ref(rdy_ref),
  .rdy_mrs(rdy_mrs), .viol(viol), .bank_idle(idle_v)
);

// File: tb/ap_bank_timer_bench.sv
`timescale 1ns/1ps
module ap_bank_timer_bench;
  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic       cmd_ap = 1'b0;
  logic [1:0] cmd_bank = 2'd0;
  logic [5:0] cfg_cl_half, cfg_wl, cfg_bl, cfg_wtr, cfg_wr, cfg_rp;
  logic rdy_act, rdy_rd, rdy_wr, rdy_pre, rdy_ref, rdy_mrs, viol;

  ap_bank_timer u_ap_bank_timer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ap(cmd_ap), .cmd_bank(cmd_bank), .cfg_cl_half(cfg_cl_half),
    .cfg_wl(cfg_wl), .cfg_bl(cfg_bl), .cfg_wtr(cfg_wtr), .cfg_wr(cfg_wr),
    .cfg_rp(cfg_rp), .rdy_act(rdy_act), .rdy_rd(rdy_rd), .rdy_wr(rdy_wr),
    .rdy_pre(rdy_pre), .rdy_ref(rdy_ref), .rdy_mrs(rdy_mrs), .viol(viol)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string ph = "R10";

  // Behavioural model: absolute cycle numbers at which things become legal
  int cyc_n;
  int rd_at, wr_at, pa_at;
  int free_at [NB];
  bit open_m [NB];
  bit viol_m;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    cyc_n = 0; rd_at = 0; wr_at = 0; pa_at = 0; viol_m = 0;
    for (int b = 0; b < NB; b++) begin free_at[b] = 0; open_m[b] = 0; end
  endtask

  function automatic bit m_idle(int b);
    return !open_m[b] && cyc_n >= free_at[b];
  endfunction

  function automatic bit m_all_idle();
    for (int b = 0; b < NB; b++) if (!m_idle(b)) return 0;
    return 1;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    model_reset();
  endtask

  // One clock: drive, compare every output, then advance the model
  task automatic cyc(bit v, int code, bit ap, int b);
    bit e_act, e_rd, e_wr, e_pre, e_ref, ok;
    int cl, hb, wl;
    @(negedge clk);
    cmd_valid = v; cmd_code = 3'(code); cmd_ap = ap; cmd_bank = 2'(b);
    #1;
    e_act = m_idle(b) && cyc_n >= pa_at;
    e_pre = cyc_n >= free_at[b] && cyc_n >= pa_at;
    e_rd  = open_m[b] && cyc_n >= rd_at;
    e_wr  = open_m[b] && cyc_n >= wr_at;
    e_ref = m_all_idle();
    chk(ph, "rdy_act", rdy_act, e_act);
    chk(ph, "rdy_pre", rdy_pre, e_pre);
    chk(ph, "rdy_rd",  rdy_rd,  e_rd);
    chk(ph, "rdy_wr",  rdy_wr,  e_wr);
    chk(ph, "rdy_ref", rdy_ref, e_ref);
    chk(ph, "rdy_mrs", rdy_mrs, e_ref);
    chk(ph, "viol",    viol,    viol_m);
    case (code)
      0: ok = 1; 1: ok = e_act; 2: ok = e_rd; 3: ok = e_wr;
      4: ok = e_pre; 5: ok = e_ref; 6: ok = e_ref; default: ok = 0;
    endcase
    cl = (int'(cfg_cl_half) + 1) / 2;
    hb = int'(cfg_bl) / 2;
    wl = int'(cfg_wl);
    @(posedge clk);
    if (v && !ok) viol_m = 1;
    else if (v) begin
      if (code == 1) open_m[b] = 1;
      if (code == 4) begin open_m[b] = 0; free_at[b] = cyc_n + int'(cfg_rp); end
      if ((code == 2 || code == 3) && ap) begin
        open_m[b] = 0;
        pa_at = cyc_n + 1;
        if (code == 3) begin
          rd_at = cyc_n + wl + hb + int'(cfg_wtr);
          wr_at = cyc_n + hb;
          free_at[b] = cyc_n + wl + hb + int'(cfg_wr) + int'(cfg_rp);
        end else begin
          rd_at = cyc_n + hb;
          wr_at = cyc_n + imax(0, cl + hb + 2 - wl);
          free_at[b] = cyc_n + hb + int'(cfg_rp);
        end
      end
    end
    cyc_n++;
  endtask

  task automatic watch(int n, int code, int b);
    repeat (n) cyc(0, code, 0, b);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    cfg_cl_half = 6'd5; cfg_wl = 6'd1; cfg_bl = 6'd8;
    cfg_wtr = 6'd2; cfg_wr = 6'd3; cfg_rp = 6'd2;
    do_reset();
    // R10: reset state
    @(negedge clk); #1;
    chk("R10", "reset rdy_act", rdy_act, 1);
    chk("R10", "reset rdy_rd",  rdy_rd,  0);
    chk("R10", "reset rdy_ref", rdy_ref, 1);
    chk("R10", "reset viol",    viol,    0);
    ph = "R1";
    for (int b = 0; b < NB; b++) cyc(1, 1, 0, b);
    cyc(1, 2, 0, 0);
    ph = "R9";
    cyc(1, 0, 0, 0);
    ph = "R2";
    cyc(1, 3, 1, 0);          // write, auto precharge, bank 0
    watch(6, 2, 1);           // read to bank 1 held
    cyc(1, 2, 0, 1);
    cyc(1, 3, 0, 2);
    ph = "R4";
    cyc(1, 2, 1, 1);          // read, auto precharge, bank 1
    cyc(1, 4, 0, 3);          // precharge other bank next clock
    watch(1, 1, 3);
    cyc(1, 1, 3, 3);
    ph = "R3";
    watch(4, 3, 3);           // write to bank 3 held after read
    cyc(1, 3, 0, 3);
    ph = "R6";
    cyc(1, 3, 1, 2);
    cyc(1, 4, 0, 3);
    ph = "R7";
    watch(8, 5, 0);
    cyc(1, 5, 0, 0);
    cyc(1, 6, 0, 0);
    ph = "R8";
    cyc(1, 2, 0, 0);          // read to closed bank: refused
    watch(2, 1, 0);
    cyc(1, 1, 0, 0);

    ph = "R5";
    cfg_cl_half = 6'd4;
    do_reset();
    cyc(1, 1, 0, 0); cyc(1, 1, 0, 1);
    cyc(1, 2, 1, 0);
    watch(6, 3, 1);
    cyc(1, 3, 0, 1);

    ph = "R3";
    cfg_cl_half = 6'd2; cfg_wl = 6'd6; cfg_bl = 6'd4;
    do_reset();
    cyc(1, 1, 0, 0); cyc(1, 1, 0, 1);
    cyc(1, 2, 1, 0);
    cyc(1, 3, 0, 1);          // clamped spacing: allowed at once
    ph = "R9";
    cyc(1, 7, 0, 1);          // reserved code
    watch(2, 2, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule